// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

The block gathers a parameterized set of maskable interrupt requests and a fixed group of non-maskable exception requests, chooses a winner and turns it into a 16-bit vector address. Every maskable channel carries a programmable priority level and a routing bit that hands it either to the main CPU or to a coprocessor. The two destinations are arbitrated separately. CPU-bound maskable requests nest: a request is taken only when its level is above the processing level the CPU reports and the CPU's I mask is clear.

The vector address is the base register in the upper byte and a fixed offset in the lower byte. The CPU strobes an acknowledge, and one clock later the registered vector holds the answer. When nothing qualifies at that moment, the answer is the spurious vector. The coprocessor side gets a channel number and a valid flag on every cycle. A wake-up output tells the power controller that a request is waiting, even while the X mask is set.

Configuration goes through a byte-wide write port with a combinational read-back. Address 0 holds the base register. Address 1+i holds channel i: bits [2:0] are the level and bit 7 is the route.

Top module: `int_vector_ctrl`

## Requirements
- R1: After reset the vector output reads 0xFFFE, the base register reads 0xFF, every channel level reads 0 with route 0, and cpu_irq_o and wake_o are low.
- R2: The vector output changes only on the clock edge at which ack_i is high. It then holds {base, offset} of the winner present at that edge, and it keeps its value on every other edge.
- R3: Maskable channel i has offset 0x1A+2*i. The channel with the highest level wins. Among channels of equal level, the higher index wins.
- R4: A CPU-routed channel qualifies only when it is requested, its level is strictly greater than cpu_level_i, and i_mask_i is 0. A channel with level 0 never qualifies and never raises wake-up.
- R5: Exceptions beat every maskable channel, in this order: trap (offset 0xF8), software interrupt (0xF6), access violation 0/1/2 (0x14/0x16/0x18, with the lower index first), system call (0x12), then the X request (0xF4), which applies only when x_mask_i is 0.
- R6: An acknowledge with no qualifying request gives offset 0x10.
- R7: A channel whose route bit (bit 7) is 1 goes to the coprocessor and is never chosen for the CPU vector.
- R8: The last channel (index NREQ-1) is the external IRQ. A write to its route bit is ignored, and the bit always reads 0.
- R9: cop_valid_o and cop_chan_o give, on every cycle, the coprocessor-routed requested channel with the highest nonzero level (ties go to the higher index). They ignore cpu_level_i and i_mask_i.
- R10: wake_o is high when any requested channel has a nonzero level or when xirq_i is high, whatever x_mask_i says.
- R11: cpu_irq_o is high exactly when an acknowledge at that time would give an offset other than 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NREQ | Maskable requests, one per channel |
| trap_i | input | 1 | Unimplemented-opcode trap request |
| swi_i | input | 1 | Software interrupt / debug request |
| accv_i | input | 3 | Access violation requests |
| sysc_i | input | 1 | System call request |
| xirq_i | input | 1 | X-maskable request |
| x_mask_i | input | 1 | X mask from the CPU |
| i_mask_i | input | 1 | I mask from the CPU |
| cpu_level_i | input | LVLW | Current CPU processing level |
| ack_i | input | 1 | Vector acknowledge strobe |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 8 | Configuration address |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data |
| vec_o | output | 16 | Registered vector address |
| cpu_irq_o | output | 1 | A qualifying CPU request exists |
| cop_valid_o | output | 1 | A coprocessor request exists |
| cop_chan_o | output | CHW | Winning coprocessor channel |
| wake_o | output | 1 | Wake-up request |

## Verification
Wrong level or route storage shows up right away, either on the read port or in cop_chan_o and cpu_irq_o on the same cycle as the request. A bad CPU priority decision shows up one clock after the acknowledge, as a wrong lower byte of vec_o. A stale base register shows up as a wrong upper byte. If the vector register updates when it should not, vec_o changes between acknowledges, and the bench catches that by checking it against the value it expects to be held.

// File: rtl/int_vector_ctrl.sv
module int_vector_ctrl #(
  parameter int NREQ = 16,
  parameter int LVLW = 3,
  localparam int CHW = $clog2(NREQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req_i,
  input  logic            trap_i,
  input  logic            swi_i,
  input  logic [2:0]      accv_i,
  input  logic            sysc_i,
  input  logic            xirq_i,
  input  logic            x_mask_i,
  input  logic            i_mask_i,
  input  logic [LVLW-1:0] cpu_level_i,
  input  logic            ack_i,
  input  logic            cfg_we_i,
  input  logic [7:0]      cfg_addr_i,
  input  logic [7:0]      cfg_wdata_i,
  output logic [7:0]      cfg_rdata_o,
  output logic [15:0]     vec_o,
  output logic            cpu_irq_o,
  output logic            cop_valid_o,
  output logic [CHW-1:0]  cop_chan_o,
  output logic            wake_o
);

  logic [7:0]      base_q;
  logic [LVLW-1:0] lvl_q [NREQ];
  logic [NREQ-1:0] route_q;
  logic [NREQ-1:0] enabled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= 8'hFF;
      route_q <= '0;
      for (int i = 0; i < NREQ; i++) lvl_q[i] <= '0;
    end else if (cfg_we_i) begin
      if (cfg_addr_i == 8'd0) base_q <= cfg_wdata_i;
      for (int i = 0; i < NREQ; i++) begin
        if (cfg_addr_i == 8'(i + 1)) begin
          lvl_q[i]   <= cfg_wdata_i[LVLW-1:0];
          route_q[i] <= (i == NREQ - 1) ? 1'b0 : cfg_wdata_i[7];
        end
      end
    end
  end

  always_comb begin
    cfg_rdata_o = (cfg_addr_i == 8'd0) ? base_q : 8'h00;
    for (int i = 0; i < NREQ; i++) begin
      if (cfg_addr_i == 8'(i + 1)) begin
        cfg_rdata_o    = 8'(lvl_q[i]);
        cfg_rdata_o[7] = route_q[i];
      end
    end
  end

  for (genvar g = 0; g < NREQ; g++) begin : g_en
    assign enabled[g] = (lvl_q[g] != '0);
  end

  logic            m_hit;
  logic [CHW-1:0]  m_idx;
  logic [LVLW-1:0] m_lvl;
  logic [LVLW-1:0] c_lvl;

  always_comb begin
    m_hit = 1'b0;
    m_idx = '0;
    m_lvl = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (req_i[i] && !route_q[i] && lvl_q[i] > cpu_level_i && lvl_q[i] >= m_lvl) begin
        m_hit = 1'b1;
        m_idx = CHW'(i);
        m_lvl = lvl_q[i];
      end
    end
  end

  always_comb begin
    cop_valid_o = 1'b0;
    cop_chan_o  = '0;
    c_lvl       = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (req_i[i] && route_q[i] && enabled[i] && lvl_q[i] >= c_lvl) begin
        cop_valid_o = 1'b1;
        cop_chan_o  = CHW'(i);
        c_lvl       = lvl_q[i];
      end
    end
  end

  logic [7:0] off;

  always_comb begin
    cpu_irq_o = 1'b1;
    if (trap_i)                   off = 8'hF8;
    else if (swi_i)               off = 8'hF6;
    else if (accv_i[0])           off = 8'h14;
    else if (accv_i[1])           off = 8'h16;
    else if (accv_i[2])           off = 8'h18;
    else if (sysc_i)              off = 8'h12;
    else if (xirq_i && !x_mask_i) off = 8'hF4;
    else if (m_hit && !i_mask_i)  off = 8'h1A + 8'({m_idx, 1'b0});
    else begin
      off       = 8'h10;
      cpu_irq_o = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vec_o <= 16'hFFFE;
    else if (ack_i) vec_o <= {base_q, off};
  end

  assign wake_o = |(req_i & enabled) | xirq_i;

  // R2
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> $stable(vec_o));
  // R2
  vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> vec_o[15:8] == $past(base_q));
  // R8
  irq_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !route_q[NREQ-1]);
  // R9
  cop_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cop_valid_o |-> req_i[cop_chan_o] && route_q[cop_chan_o]);
  // R10
  wake_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xirq_i |-> wake_o);

endmodule

// File: tb/tb_int_vector_ctrl.sv
module tb_int_vector_ctrl;
  localparam int NREQ = 16;
  localparam int CHW  = 4;

  logic clk = 0, rst_n = 0;
  logic [NREQ-1:0] req_i = '0;
  logic trap_i = 0, swi_i = 0, sysc_i = 0, xirq_i = 0, x_mask_i = 0, i_mask_i = 0;
  logic [2:0] accv_i = '0, cpu_level_i = '0;
  logic ack_i = 0, cfg_we_i = 0;
  logic [7:0] cfg_addr_i = '0, cfg_wdata_i = '0, cfg_rdata_o;
  logic [15:0] vec_o;
  logic cpu_irq_o, cop_valid_o, wake_o;
  logic [CHW-1:0] cop_chan_o;
  int total = 0, bad = 0;

  int_vector_ctrl #(.NREQ(NREQ), .LVLW(3)) dut (.*);

  always #4 clk = ~clk;

  task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk); cfg_we_i = 0;
  endtask

  task automatic ack();
    @(negedge clk); ack_i = 1;
    @(negedge clk); ack_i = 0;
  endtask

  // {req, cpu_level, i_mask, expected vector}, base 0x40
  localparam logic [35:0] TBL [10] = '{
    {16'h0004, 3'd0, 1'b0, 16'h401E},
    {16'h0024, 3'd0, 1'b0, 16'h4024},
    {16'h0084, 3'd0, 1'b0, 16'h4028},
    {16'h0080, 3'd6, 1'b0, 16'h4010},
    {16'h0080, 3'd5, 1'b0, 16'h4028},
    {16'h0200, 3'd0, 1'b0, 16'h4010},
    {16'h8000, 3'd1, 1'b0, 16'h4038},
    {16'h0001, 3'd0, 1'b0, 16'h4010},
    {16'h0004, 3'd0, 1'b1, 16'h4010},
    {16'h8020, 3'd2, 1'b0, 16'h4024}
  };

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20; @(negedge clk); rst_n = 1; #1;
    // R1 reset state
    chk("R1 vec", vec_o, 16'hFFFE);
    chk("R1 base", {8'h0, cfg_rdata_o}, 16'h00FF);
    cfg_addr_i = 8'd3; #1;
    chk("R1 chan", {8'h0, cfg_rdata_o}, 16'h0000);
    chk("R1 flags", {14'h0, cpu_irq_o, wake_o}, 16'h0);

    wr(8'd0, 8'h40);
    wr(8'd3, 8'h03);   // ch2 lvl3 cpu
    wr(8'd6, 8'h03);   // ch5 lvl3 cpu
    wr(8'd8, 8'h06);   // ch7 lvl6 cpu
    wr(8'd10, 8'h85);  // ch9 lvl5 coprocessor
    wr(8'd16, 8'h82);  // ch15 IRQ lvl2, route write ignored
    cfg_addr_i = 8'd16; #1;
    chk("R8 irq route", {8'h0, cfg_rdata_o}, 16'h0002);

    // R3 R4 R6 R7 R8 vector table
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      req_i = TBL[k][35:20]; cpu_level_i = TBL[k][19:17]; i_mask_i = TBL[k][16];
      #1;
      chk("R11 irq flag", {15'h0, cpu_irq_o}, {15'h0, TBL[k][15:0] != 16'h4010});
      ack(); #1;
      chk("R3/R4/R6/R7 vec", vec_o, TBL[k][15:0]);
    end

    // R2 hold without ack
    @(negedge clk); req_i = 16'h0004; cpu_level_i = 0; i_mask_i = 0;
    repeat (3) @(negedge clk); #1;
    chk("R2 hold", vec_o, 16'h4024);
    ack(); #1;
    chk("R2 update", vec_o, 16'h401E);

    // R9 coprocessor arbiter ignores level and mask
    @(negedge clk); req_i = 16'h0200; cpu_level_i = 3'd7; i_mask_i = 1; #1;
    chk("R9 cop", {11'h0, cop_valid_o, cop_chan_o}, {11'h0, 1'b1, 4'd9});
    @(negedge clk); req_i = 16'h0004; #1;
    chk("R9 cop none", {15'h0, cop_valid_o}, 16'h0);

    // R5 exception order
    @(negedge clk); req_i = 16'h0084; cpu_level_i = 0; i_mask_i = 0;
    trap_i = 1; swi_i = 1; accv_i = 3'b111; sysc_i = 1; xirq_i = 1;
    ack(); #1; chk("R5 trap", vec_o, 16'h40F8);
    trap_i = 0; ack(); #1; chk("R5 swi", vec_o, 16'h40F6);
    swi_i = 0; ack(); #1; chk("R5 acc0", vec_o, 16'h4014);
    accv_i = 3'b110; ack(); #1; chk("R5 acc1", vec_o, 16'h4016);
    accv_i = 3'b100; ack(); #1; chk("R5 acc2", vec_o, 16'h4018);
    accv_i = 0; ack(); #1; chk("R5 sys", vec_o, 16'h4012);
    sysc_i = 0; ack(); #1; chk("R5 xirq", vec_o, 16'h40F4);
    x_mask_i = 1; ack(); #1; chk("R5 xmask", vec_o, 16'h4028);

    // R10 wake-up
    @(negedge clk); req_i = '0; #1;
    chk("R10 wake xirq masked", {15'h0, wake_o}, 16'h1);
    xirq_i = 0; #1;
    chk("R10 no wake", {15'h0, wake_o}, 16'h0);
    req_i = 16'h0001; #1;
    chk("R10 lvl0 no wake", {15'h0, wake_o}, 16'h0);
    req_i = 16'h0200; #1;
    chk("R10 cop wake", {15'h0, wake_o}, 16'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule